// File: doc/BRIEF.md
# Burst-Capable Memory Slave on an AXI4 Port

This block is a memory-backed slave on an AXI4 port, with a small internal RAM. Writes and reads run on separate channels, and each channel uses a valid/ready handshake. On a write, the master sends one address beat carrying an ID, a beat count and an address-step mode. It then streams the data beats with byte strobes. The slave returns one response for the whole burst, tagged with the same ID. On a read, the slave returns the requested number of beats. Each beat carries the request ID and a response code, and the final beat is flagged.

The slave handles one write burst and one read burst at a time. The two directions run independently of each other. Byte addresses are converted to word indices by dropping the low address bits, so beats are always word aligned. A burst that would touch a word outside the RAM is still run for its full number of beats. Such a burst, or one whose mode or length is illegal, never changes memory and reports a slave error on every response.

Top module: `axi_burst_ram`

## Requirements
- R1: While `rst_n` is low, `s_bvalid` and `s_rvalid` are low, including when reset arrives in the middle of a burst. After reset is released, `s_awready` and `s_arready` are high and `s_wready` is low.
- R2: Once `s_bvalid` or `s_rvalid` rises, it stays high, with ID, response, data and last flag unchanged, until the matching ready is sampled high.
- R3: On a write beat, byte lane i of `s_wdata` is stored only when `s_wstrb[i]` is 1. A beat with all strobe bits at 0 leaves the addressed word unchanged.
- R4: A write burst takes exactly `s_awlen`+1 data beats. `s_bvalid` stays low until the last of them, rises on the clock edge after the final beat is accepted, and is given once per burst with `s_bid` equal to `s_awid`.
- R5: `s_awready` is low from the address handshake of a write burst until its response handshake. `s_wready` is high only between the address handshake and the last data beat.
- R6: `s_rvalid` never rises before the read address handshake. A read returns exactly `s_arlen`+1 beats. `s_rlast` is 1 only on the final beat, and `s_rid` equals `s_arid`.
- R7: Burst mode 2'b00 (fixed) uses the starting word for every beat.
- R8: Burst mode 2'b10 (wrap) steps upward inside an aligned window of `len`+1 words and returns to the window base after its top word. Only lengths of 2, 4, 8 or 16 beats are legal; any other length is an error burst.
- R9: Burst mode 2'b01 (incrementing) steps to the next word on each beat.
- R10: Responses are coded OKAY=2'b00 and SLVERR=2'b10. A burst whose highest touched word index is at or above `DEPTH` gets SLVERR on every response, writes nothing and returns all-zero read data. All other legal bursts get OKAY.
- R11: Burst mode 2'b11 is an error burst with the same handling as in R10.
- R12: No output depends combinationally on an input. The first read beat is presented on the second clock edge after the read address handshake, and later beats follow with no gap while `s_rready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awid | input | ID_W | Write burst ID |
| s_awaddr | input | ADDR_W | Write start byte address |
| s_awlen | input | 8 | Write beats minus one |
| s_awburst | input | 2 | Write address-step mode |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write beat data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_wlast | input | 1 | Final write beat marker (beat count is kept internally) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bid | output | ID_W | Response ID |
| s_bresp | output | 2 | Write burst response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_arid | input | ID_W | Read burst ID |
| s_araddr | input | ADDR_W | Read start byte address |
| s_arlen | input | 8 | Read beats minus one |
| s_arburst | input | 2 | Read address-step mode |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rid | output | ID_W | Read beat ID |
| s_rdata | output | DATA_W | Read beat data |
| s_rresp | output | 2 | Read beat response |
| s_rlast | output | 1 | Final read beat |
| s_rvalid | output | 1 | Read beat valid |
| s_rready | input | 1 | Read beat taken |

## Verification
Each side keeps a remaining-beat counter and an error flag. A fault in either one shows at the ports on the beat where it takes effect. A miscounted write raises `s_bvalid` too early, or never raises it. A miscounted read moves `s_rlast` off the final beat, or leaves `s_rvalid` high after it. A wrong step-mode decode puts the wrong word on the very first read beat that follows the faulty step. A stale error flag flips `s_bresp` or `s_rresp` within the same burst. Each read-back is compared word for word against a model held in the bench, so a corrupted lane or address shows up one read burst after the faulty write.

// File: rtl/abr_pkg.sv
package abr_pkg;

  localparam int LEN_W = 8;

  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [1:0] {
    WS_ADDR = 2'd0,
    WS_DATA = 2'd1,
    WS_RESP = 2'd2
  } wr_state_e;

  typedef enum logic [1:0] {
    RS_ADDR = 2'd0,
    RS_LOAD = 2'd1,
    RS_DATA = 2'd2
  } rd_state_e;

  // Wrap bursts are only legal with 2, 4, 8 or 16 beats.
  function automatic logic wrap_len_legal(input logic [LEN_W-1:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

endpackage

// File: rtl/abr_burst_seq.sv
// Beat sequencer: holds the current word index, the remaining beat count
// and the error verdict of one burst.
module abr_burst_seq
  import abr_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [LEN_W-1:0] len,
  input  logic [1:0]       burst,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] next_idx,
  output logic             last_beat,
  output logic             penult_beat,
  output logic             bad
);

  localparam int RW = IDX_W + 1;

  logic [IDX_W-1:0] cur_q, cur_d;
  logic [IDX_W-1:0] mask_q, mask_d;
  burst_e           kind_q, kind_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             bad_q, bad_d;
  logic             seq_en;

  logic [IDX_W-1:0] len_ext;
  logic [RW-1:0]    reach;
  logic             bad_new;

  // Verdict at burst acceptance: the highest word the burst will touch.
  always_comb begin
    len_ext = IDX_W'(len);
    case (burst_e'(burst))
      BT_FIXED: reach = {1'b0, start_idx};
      BT_INCR:  reach = {1'b0, start_idx} + {1'b0, len_ext};
      BT_WRAP:  reach = {1'b0, start_idx | len_ext};
      default:  reach = '0;
    endcase
    bad_new = (burst_e'(burst) == BT_RSVD)
           || ((burst_e'(burst) == BT_WRAP) && !wrap_len_legal(len))
           || (reach >= RW'(DEPTH));
  end

  // Address step for the burst in flight.
  always_comb begin
    case (kind_q)
      BT_FIXED: next_idx = cur_q;
      BT_WRAP:  next_idx = (cur_q & ~mask_q) | ((cur_q + IDX_W'(1)) & mask_q);
      default:  next_idx = cur_q + IDX_W'(1);
    endcase
  end

  always_comb begin
    cur_d  = cur_q;
    mask_d = mask_q;
    kind_d = kind_q;
    left_d = left_q;
    bad_d  = bad_q;
    seq_en = load | step;
    if (load) begin
      cur_d  = start_idx;
      mask_d = len_ext;
      kind_d = burst_e'(burst);
      left_d = len;
      bad_d  = bad_new;
    end else if (step) begin
      cur_d  = next_idx;
      left_d = left_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      mask_q <= '0;
      kind_q <= BT_FIXED;
      left_q <= '0;
      bad_q  <= 1'b0;
    end else if (seq_en) begin
      cur_q  <= cur_d;
      mask_q <= mask_d;
      kind_q <= kind_d;
      left_q <= left_d;
      bad_q  <= bad_d;
    end
  end

  assign cur_idx     = cur_q;
  assign last_beat   = (left_q == '0);
  assign penult_beat = (left_q == LEN_W'(1));
  assign bad         = bad_q;

endmodule

// File: rtl/abr_ram.sv
// Word-organised RAM, one storage array per byte lane, asynchronous read.
module abr_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [DATA_W/8-1:0]   wr_strb,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]     rd_data
);

  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_strb[g]) begin
        cells[wr_idx] <= wr_data[g*8 +: 8];
      end
    end

    assign rd_data[g*8 +: 8] = cells[rd_idx];
  end

endmodule

// File: rtl/axi_burst_ram.sv
module axi_burst_ram
  import abr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [1:0]        s_awburst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic              s_wlast,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [7:0]        s_arlen,
  input  logic [1:0]        s_arburst,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready
);

  localparam int STRB_W = DATA_W / 8;
  localparam int OFF    = $clog2(STRB_W);
  localparam int IDX_W  = ADDR_W - OFF;
  localparam int MEM_AW = $clog2(DEPTH);

  // ---------------- write side ----------------
  wr_state_e        w_state_q, w_state_d;
  logic [ID_W-1:0]  bid_q;
  logic             aw_hs, w_hs, b_hs;
  logic [IDX_W-1:0] w_cur, w_next;
  logic             w_last, w_pen, w_bad;

  assign aw_hs = s_awvalid & (w_state_q == WS_ADDR);
  assign w_hs  = s_wvalid  & (w_state_q == WS_DATA);
  assign b_hs  = s_bready  & (w_state_q == WS_RESP);

  abr_burst_seq #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_wseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (aw_hs),
    .step       (w_hs),
    .start_idx  (s_awaddr[ADDR_W-1:OFF]),
    .len        (s_awlen),
    .burst      (s_awburst),
    .cur_idx    (w_cur),
    .next_idx   (w_next),
    .last_beat  (w_last),
    .penult_beat(w_pen),
    .bad        (w_bad)
  );

  always_comb begin
    w_state_d = w_state_q;
    case (w_state_q)
      WS_ADDR: if (aw_hs)           w_state_d = WS_DATA;
      WS_DATA: if (w_hs && w_last)  w_state_d = WS_RESP;
      WS_RESP: if (b_hs)            w_state_d = WS_ADDR;
      default:                      w_state_d = WS_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_state_q <= WS_ADDR;
    end else begin
      w_state_q <= w_state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bid_q <= '0;
    end else if (aw_hs) begin
      bid_q <= s_awid;
    end
  end

  // ---------------- read side ----------------
  rd_state_e        r_state_q, r_state_d;
  logic [ID_W-1:0]  rid_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic             rlast_q, rlast_d;
  logic             beat_en;
  logic             ar_hs, r_hs;
  logic [IDX_W-1:0] r_cur, r_next, r_sel;
  logic             r_last, r_pen, r_bad;
  logic [DATA_W-1:0] ram_rdata, beat_word;

  assign ar_hs = s_arvalid & (r_state_q == RS_ADDR);
  assign r_hs  = s_rready  & (r_state_q == RS_DATA);

  abr_burst_seq #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_rseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ar_hs),
    .step       (r_hs),
    .start_idx  (s_araddr[ADDR_W-1:OFF]),
    .len        (s_arlen),
    .burst      (s_arburst),
    .cur_idx    (r_cur),
    .next_idx   (r_next),
    .last_beat  (r_last),
    .penult_beat(r_pen),
    .bad        (r_bad)
  );

  always_comb begin
    r_state_d = r_state_q;
    case (r_state_q)
      RS_ADDR: if (ar_hs)           r_state_d = RS_LOAD;
      RS_LOAD:                      r_state_d = RS_DATA;
      RS_DATA: if (r_hs && r_last)  r_state_d = RS_ADDR;
      default:                      r_state_d = RS_ADDR;
    endcase
  end

  // Beat register: first beat loaded in RS_LOAD, later beats on each
  // accepted beat, so a steady ready gives one beat per cycle.
  always_comb begin
    r_sel     = (r_state_q == RS_LOAD) ? r_cur : r_next;
    beat_word = r_bad ? '0 : ram_rdata;
    rdata_d   = rdata_q;
    rlast_d   = rlast_q;
    beat_en   = 1'b0;
    if (r_state_q == RS_LOAD) begin
      beat_en = 1'b1;
      rdata_d = beat_word;
      rlast_d = r_last;
    end else if (r_hs && !r_last) begin
      beat_en = 1'b1;
      rdata_d = beat_word;
      rlast_d = r_pen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_state_q <= RS_ADDR;
    end else begin
      r_state_q <= r_state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rid_q <= '0;
    end else if (ar_hs) begin
      rid_q <= s_arid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rlast_q <= 1'b0;
    end else if (beat_en) begin
      rdata_q <= rdata_d;
      rlast_q <= rlast_d;
    end
  end

  // ---------------- storage ----------------
  abr_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk    (clk),
    .wr_en  (w_hs & ~w_bad),
    .wr_idx (w_cur[MEM_AW-1:0]),
    .wr_data(s_wdata),
    .wr_strb(s_wstrb),
    .rd_idx (r_sel[MEM_AW-1:0]),
    .rd_data(ram_rdata)
  );

  // The beat count is kept internally; the last-beat marker and the byte
  // offset bits carry no information this block needs.
  logic unused_bits;
  assign unused_bits = ^{s_wlast, s_awaddr, s_araddr, w_next, w_pen, w_cur, r_cur, r_next};

  // ---------------- outputs ----------------
  assign s_awready = (w_state_q == WS_ADDR);
  assign s_wready  = (w_state_q == WS_DATA);
  assign s_bvalid  = (w_state_q == WS_RESP);
  assign s_bid     = bid_q;
  assign s_bresp   = w_bad ? RSP_SLVERR : RSP_OKAY;

  assign s_arready = (r_state_q == RS_ADDR);
  assign s_rvalid  = (r_state_q == RS_DATA);
  assign s_rid     = rid_q;
  assign s_rdata   = rdata_q;
  assign s_rlast   = rlast_q;
  assign s_rresp   = r_bad ? RSP_SLVERR : RSP_OKAY;

endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic [7:0]        awlen,
  input logic              wvalid,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [ID_W-1:0]   bid,
  input logic [1:0]        bresp,
  input logic              arvalid,
  input logic              arready,
  input logic [7:0]        arlen,
  input logic              rvalid,
  input logic              rready,
  input logic [ID_W-1:0]   rid,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              rlast
);

  logic       w_open, r_open;
  logic [7:0] w_len, r_len, r_cnt;
  logic [8:0] w_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_open <= 1'b0;
      w_len  <= '0;
      w_cnt  <= '0;
    end else begin
      if (awvalid && awready) begin
        w_open <= 1'b1;
        w_len  <= awlen;
        w_cnt  <= '0;
      end else begin
        if (w_open && wvalid && wready) w_cnt <= w_cnt + 9'd1;
        if (bvalid && bready)           w_open <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_open <= 1'b0;
      r_len  <= '0;
      r_cnt  <= '0;
    end else begin
      if (arvalid && arready) begin
        r_open <= 1'b1;
        r_len  <= arlen;
        r_cnt  <= '0;
      end else if (rvalid && rready) begin
        r_cnt <= r_cnt + 8'd1;
        if (rlast) r_open <= 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!rvalid && !bvalid);
    end
  end

  p_b_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && $stable(bresp) && $stable(bid));

  p_r_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp)
                          && $stable(rlast) && $stable(rid));

  p_b_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> (w_cnt == {1'b0, w_len} + 9'd1));

  p_b_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && bready |=> !bvalid);

  p_aw_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_open |-> !awready);

  p_r_after_ar_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> r_open);

  p_rlast_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rlast == (r_cnt == r_len)));

  p_bresp_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00 || bresp == 2'b10));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && (rresp == 2'b10) |-> (rdata == '0));

endmodule

bind axi_burst_ram abr_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_abr_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .awvalid(s_awvalid),
  .awready(s_awready),
  .awlen  (s_awlen),
  .wvalid (s_wvalid),
  .wready (s_wready),
  .bvalid (s_bvalid),
  .bready (s_bready),
  .bid    (s_bid),
  .bresp  (s_bresp),
  .arvalid(s_arvalid),
  .arready(s_arready),
  .arlen  (s_arlen),
  .rvalid (s_rvalid),
  .rready (s_rready),
  .rid    (s_rid),
  .rdata  (s_rdata),
  .rresp  (s_rresp),
  .rlast  (s_rlast)
);

// File: tb/tb_axi_burst_ram.sv
module tb_axi_burst_ram;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int ID_W   = 4;
  localparam int DEPTH  = 64;

  logic              clk, rst_n;
  logic [ID_W-1:0]   s_awid, s_arid, s_bid, s_rid;
  logic [ADDR_W-1:0] s_awaddr, s_araddr;
  logic [7:0]        s_awlen, s_arlen;
  logic [1:0]        s_awburst, s_arburst, s_bresp, s_rresp;
  logic              s_awvalid, s_awready, s_wlast, s_wvalid, s_wready;
  logic              s_bvalid, s_bready, s_arvalid, s_arready;
  logic              s_rlast, s_rvalid, s_rready;
  logic [DATA_W-1:0] s_wdata, s_rdata;
  logic [3:0]        s_wstrb;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model [DEPTH];

  axi_burst_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awburst(s_awburst),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bid(s_bid), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_arid(s_arid), .s_araddr(s_araddr), .s_arlen(s_arlen), .s_arburst(s_arburst),
    .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
    .s_rvalid(s_rvalid), .s_rready(s_rready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Highest touched word at or above DEPTH, reserved mode, or bad wrap length.
  function automatic bit bad_burst(input int sw, input int len, input int bt);
    int top;
    if (bt == 3) return 1'b1;
    if (bt == 2 && !(len == 1 || len == 3 || len == 7 || len == 15)) return 1'b1;
    case (bt)
      0:       top = sw;
      1:       top = sw + len;
      default: top = (sw / (len + 1)) * (len + 1) + len;
    endcase
    return top >= DEPTH;
  endfunction

  function automatic int beat_idx(input int sw, input int len, input int bt, input int k);
    int base;
    case (bt)
      0:       return sw;
      1:       return sw + k;
      default: begin
        base = (sw / (len + 1)) * (len + 1);
        return base + ((sw - base + k) % (len + 1));
      end
    endcase
  endfunction

  task automatic wr_burst(input int id, input int sw, input int len, input int bt,
                          input logic [31:0] seed, input logic [3:0] strb,
                          input int gap, input string req);
    bit hs;
    bit bad;
    int idx;
    logic [31:0] d;
    bad = bad_burst(sw, len, bt);
    @(negedge clk);
    s_awid = ID_W'(id); s_awaddr = ADDR_W'(sw * 4); s_awlen = 8'(len);
    s_awburst = 2'(bt); s_awvalid = 1'b1;
    do begin hs = s_awready; @(negedge clk); end while (!hs);
    s_awvalid = 1'b0;
    chk_eq({req, " R5 awready low after address"}, 64'(s_awready), 64'd0);
    for (int k = 0; k <= len; k++) begin
      repeat (gap) @(negedge clk);
      d = seed + 32'(k) * 32'h01010101;
      s_wdata = d; s_wstrb = strb; s_wlast = (k == len); s_wvalid = 1'b1;
      do begin hs = s_wready; @(negedge clk); end while (!hs);
      s_wvalid = 1'b0; s_wlast = 1'b0;
      if (!bad) begin
        idx = beat_idx(sw, len, bt, k);
        for (int b = 0; b < 4; b++) if (strb[b]) model[idx][b*8 +: 8] = d[b*8 +: 8];
      end
      if (k < len) chk_eq({req, " R4 no early bvalid"}, 64'(s_bvalid), 64'd0);
    end
    chk_eq({req, " R4 bvalid after last beat"}, 64'(s_bvalid), 64'd1);
    chk_eq({req, " R4 bid"}, 64'(s_bid), 64'(id));
    chk_eq({req, " R10 bresp"}, 64'(s_bresp), bad ? 64'd2 : 64'd0);
    chk_eq({req, " R5 awready held low"}, 64'(s_awready), 64'd0);
    s_bready = 1'b0;
    @(negedge clk);
    chk_eq({req, " R2 bvalid held"}, 64'(s_bvalid), 64'd1);
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
    chk_eq({req, " R4 single response"}, 64'(s_bvalid), 64'd0);
    chk_eq({req, " R5 awready back"}, 64'(s_awready), 64'd1);
  endtask

  task automatic rd_burst(input int id, input int sw, input int len, input int bt,
                          input bit stall, input string req);
    bit hs;
    bit bad;
    logic [31:0] e;
    bad = bad_burst(sw, len, bt);
    @(negedge clk);
    s_arid = ID_W'(id); s_araddr = ADDR_W'(sw * 4); s_arlen = 8'(len);
    s_arburst = 2'(bt); s_arvalid = 1'b1;
    do begin hs = s_arready; @(negedge clk); end while (!hs);
    s_arvalid = 1'b0;
    chk_eq({req, " R12 no rvalid one edge after address"}, 64'(s_rvalid), 64'd0);
    @(negedge clk);
    chk_eq({req, " R12 rvalid second edge"}, 64'(s_rvalid), 64'd1);
    for (int k = 0; k <= len; k++) begin
      e = bad ? 32'd0 : model[beat_idx(sw, len, bt, k)];
      if (stall) begin
        s_rready = 1'b0;
        @(negedge clk);
        chk_eq({req, " R2 rvalid held"}, 64'(s_rvalid), 64'd1);
        chk_eq({req, " R2 rdata held"}, 64'(s_rdata), 64'(e));
      end
      s_rready = 1'b1;
      chk_eq({req, " R6 rvalid"}, 64'(s_rvalid), 64'd1);
      chk_eq({req, " data"}, 64'(s_rdata), 64'(e));
      chk_eq({req, " R10 rresp"}, 64'(s_rresp), bad ? 64'd2 : 64'd0);
      chk_eq({req, " R6 rlast"}, 64'(s_rlast), 64'(k == len));
      chk_eq({req, " R6 rid"}, 64'(s_rid), 64'(id));
      @(negedge clk);
    end
    s_rready = 1'b0;
    chk_eq({req, " R6 beat count"}, 64'(s_rvalid), 64'd0);
    chk_eq({req, " R6 arready back"}, 64'(s_arready), 64'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    s_awvalid = 0; s_wvalid = 0; s_bready = 0; s_arvalid = 0; s_rready = 0;
    s_awid = '0; s_awaddr = '0; s_awlen = '0; s_awburst = '0;
    s_wdata = '0; s_wstrb = '0; s_wlast = 0;
    s_arid = '0; s_araddr = '0; s_arlen = '0; s_arburst = '0;
    repeat (3) @(negedge clk);
    chk_eq("R1 bvalid in reset", 64'(s_bvalid), 64'd0);
    chk_eq("R1 rvalid in reset", 64'(s_rvalid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 awready after reset", 64'(s_awready), 64'd1);
    chk_eq("R1 arready after reset", 64'(s_arready), 64'd1);
    chk_eq("R1 wready after reset", 64'(s_wready), 64'd0);
  endtask

  task automatic t_incr;
    wr_burst(3, 4, 3, 1, 32'hA000_0010, 4'hF, 0, "R9 incr write");
    rd_burst(5, 4, 3, 1, 1'b0, "R9 incr read");
  endtask

  task automatic t_strobe;
    wr_burst(2, 4, 0, 1, 32'h1122_3344, 4'b0101, 0, "R3 partial strobe");
    wr_burst(2, 5, 1, 1, 32'hDEAD_BEEF, 4'b0000, 1, "R3 zero strobe");
    rd_burst(6, 4, 2, 1, 1'b1, "R3 strobe readback");
  endtask

  task automatic t_fixed;
    wr_burst(1, 10, 3, 0, 32'h5000_0000, 4'hF, 1, "R7 fixed write");
    rd_burst(1, 10, 2, 0, 1'b0, "R7 fixed read");
    rd_burst(7, 10, 0, 1, 1'b0, "R7 fixed single");
  endtask

  task automatic t_wrap;
    wr_burst(4, 16, 7, 1, 32'h7000_0000, 4'hF, 0, "R8 fill");
    wr_burst(4, 22, 3, 2, 32'h9000_0001, 4'hF, 0, "R8 wrap write");
    rd_burst(4, 16, 7, 1, 1'b0, "R8 wrap order");
    rd_burst(9, 21, 7, 2, 1'b1, "R8 wrap read");
    wr_burst(4, 16, 2, 2, 32'hBAD0_0000, 4'hF, 0, "R8 wrap illegal length");
    rd_burst(4, 16, 2, 1, 1'b0, "R8 illegal wrap no write");
  endtask

  task automatic t_range;
    wr_burst(8, 62, 1, 1, 32'h6200_0000, 4'hF, 0, "R10 top words");
    wr_burst(8, 62, 3, 1, 32'hEEEE_0000, 4'hF, 0, "R10 write past end");
    rd_burst(8, 62, 1, 1, 1'b0, "R10 no write past end");
    rd_burst(8, 62, 3, 1, 1'b1, "R10 read past end");
    rd_burst(8, 100, 0, 0, 1'b0, "R10 read out of range");
  endtask

  task automatic t_rsvd;
    wr_burst(12, 4, 1, 3, 32'hCCCC_0000, 4'hF, 0, "R11 reserved write");
    rd_burst(12, 4, 1, 3, 1'b0, "R11 reserved read");
    rd_burst(12, 4, 1, 1, 1'b0, "R11 no write by reserved");
  endtask

  task automatic t_mid_reset;
    bit hs;
    @(negedge clk);
    s_arid = 4'd3; s_araddr = 16'(4 * 4); s_arlen = 8'd3; s_arburst = 2'b01; s_arvalid = 1'b1;
    do begin hs = s_arready; @(negedge clk); end while (!hs);
    s_arvalid = 1'b0;
    @(negedge clk);
    chk_eq("R1 read running before reset", 64'(s_rvalid), 64'd1);
    rst_n = 1'b0;
    #1;
    chk_eq("R1 rvalid drops at reset", 64'(s_rvalid), 64'd0);
    repeat (2) @(negedge clk);
    chk_eq("R1 rvalid stays low in reset", 64'(s_rvalid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 arready after mid reset", 64'(s_arready), 64'd1);
    chk_eq("R1 no stale beat", 64'(s_rvalid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_incr();
    t_strobe();
    t_fixed();
    t_wrap();
    t_range();
    t_rsvd();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule